// File: doc/BRIEF.md
# Per-Source Configurable Interrupt Controller

The block gathers 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt and a critical (machine-check class) interrupt. Each source is first synchronized. Software then selects for that source level or edge sensing, the active polarity, and which of the two outputs it drives. Every setting is one bit per source in a small register bus.

A sticky status register records which sources have been detected. Software clears bits in it by writing ones. An enable register gates status into a masked view. The two outputs are registered ORs of the masked bits routed to each of them. The block also reports, as a source number, the pending and enabled source that wins a priority search. A one-bit order setting picks the direction of that search. Sources 17 to 19 are reserved and take no part in any of this.

Top module: `irq_hub`

## Requirements
- R1: Source n enters on `irq_i[31-n]` and occupies bit 31-n of every register, so source 0 is the most significant bit.
- R2: Register map (on `addr_i`): 0 status, 1 enable, 2 masked status (read-only, writes ignored), 3 trigger, 4 polarity, 5 route, 6 order (bit 0). A write to status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A level-sensed source (trigger bit 0) sets its status bit on every clock while its synchronized input is active. A clear is therefore overridden while the input stays active. The status bit remains set after the input goes inactive, until it is cleared.
- R4: An edge-sensed source (trigger bit 1) sets its status bit only on an inactive-to-active transition of its synchronized input. After a clear, the bit stays 0 while the input is held active.
- R5: Polarity bit 1 makes a high level or a rising edge active. Polarity bit 0 makes a low level or a falling edge active.
- R6: Route bit 1 sends a source to `irq_o`. Route bit 0 sends it to `crit_o`. Each output is the registered OR of the masked-status bits routed to it.
- R7: Masked status equals status AND enable. A pending source that is disabled asserts no output and is not reported as pending.
- R8: With order 0, `pend_idx_o` is the lowest-numbered source set in masked status. With order 1, it is the highest-numbered such source. `pend_vld_o` is 0 when masked status is zero.
- R9: Status and enable bits of sources 17 to 19 (bits 14 to 12) always read 0. These sources never assert an output and are never reported as pending.
- R10: After reset: status, enable and trigger are 0; polarity and route are all ones; order is 0; both outputs and `pend_vld_o` are 0.
- R11: An input change reaches status after three clock edges (two synchronizer stages and then capture). It reaches `irq_o`/`crit_o` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Raw request lines, source n on bit 31-n |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 3 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Normal interrupt |
| crit_o | output | 1 | Critical interrupt |
| pend_idx_o | output | 5 | Winning pending source number |
| pend_vld_o | output | 1 | Some enabled source is pending |

## Verification
The first pattern is a level input that is held while a clear is written, then dropped and cleared. It separates sticky, overriding level capture from a plain latch. The second pattern is an edge input held high across a clear and then pulsed again. It separates edge qualification from level capture. Falling-edge and active-low cases separate polarity from sensing mode. Two simultaneous pending sources, read under both order settings, separate the two priority directions. Disabled sources, critical routing and driven reserved lines show that only routed, enabled and unreserved bits reach the outputs.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NSRC = 32;
  localparam int IW   = $clog2(NSRC);
  localparam int AW   = 3;
  localparam logic [NSRC-1:0] RSVD_MASK = 32'h0000_7000; // sources 17..19

  typedef enum logic [AW-1:0] {
    A_STAT  = 3'd0,
    A_EN    = 3'd1,
    A_MSK   = 3'd2,
    A_TRIG  = 3'd3,
    A_POL   = 3'd4,
    A_ROUTE = 3'd5,
    A_ORDER = 3'd6
  } addr_e;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_hub_sense.sv
module irq_hub_sense #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] act, act_q;

  assign act = ~(sync_i ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act;
  end

  assign set_o = (trig_i & act & ~act_q) | (~trig_i & act);
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic [NSRC-1:0] set_i,
  output logic [NSRC-1:0] rdata_o,
  output logic [NSRC-1:0] masked_o,
  output logic [NSRC-1:0] trig_o,
  output logic [NSRC-1:0] pol_o,
  output logic [NSRC-1:0] route_o,
  output logic            order_o
);
  logic [NSRC-1:0] status_q, enable_q, trig_q, pol_q, route_q;
  logic            order_q;
  logic            wr;
  logic [NSRC-1:0] clr;

  assign wr  = req_i & we_i;
  assign clr = (wr && addr_i == A_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      trig_q   <= '0;
      pol_q    <= '1;
      route_q  <= '1;
      order_q  <= 1'b0;
    end else begin
      // capture dominates clear so an active level re-asserts
      status_q <= ((status_q & ~clr) | set_i) & ~RSVD_MASK;
      if (wr) begin
        case (addr_i)
          A_EN:    enable_q <= wdata_i & ~RSVD_MASK;
          A_TRIG:  trig_q   <= wdata_i;
          A_POL:   pol_q    <= wdata_i;
          A_ROUTE: route_q  <= wdata_i;
          A_ORDER: order_q  <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  assign masked_o = status_q & enable_q;
  assign trig_o   = trig_q;
  assign pol_o    = pol_q;
  assign route_o  = route_q;
  assign order_o  = order_q;

  always_comb begin
    case (addr_i)
      A_STAT:  rdata_o = status_q;
      A_EN:    rdata_o = enable_q;
      A_MSK:   rdata_o = masked_o;
      A_TRIG:  rdata_o = trig_q;
      A_POL:   rdata_o = pol_q;
      A_ROUTE: rdata_o = route_q;
      A_ORDER: rdata_o = {{(NSRC-1){1'b0}}, order_q};
      default: rdata_o = '0;
    endcase
  end

  // R2: bits written as one and not re-captured are gone next cycle
  p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_STAT) |=> ((status_q & $past(wdata_i & ~set_i)) == '0));

  // R3: a captured source is pending on the next cycle
  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i & ~RSVD_MASK)) == $past(set_i & ~RSVD_MASK)));
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio
  import irq_hub_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] masked_i,
  input  logic            order_i,
  output logic [IW-1:0]   idx_o,
  output logic            vld_o
);
  logic [IW-1:0] idx_lo, idx_hi;

  always_comb begin
    idx_lo = '0;
    idx_hi = '0;
    for (int n = NSRC-1; n >= 0; n--)
      if (masked_i[NSRC-1-n]) idx_lo = IW'(n);
    for (int n = 0; n < NSRC; n++)
      if (masked_i[NSRC-1-n]) idx_hi = IW'(n);
  end

  assign idx_o = order_i ? idx_hi : idx_lo;
  assign vld_o = |masked_i;

  // R8: reported source is actually pending, none reported when idle
  p_idx_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> masked_i[NSRC-1-int'(idx_o)]);
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_i == '0) |-> !vld_o);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o,
  output logic            crit_o,
  output logic [IW-1:0]   pend_idx_o,
  output logic            pend_vld_o
);
  logic [NSRC-1:0] sync, set, masked, trig, pol, route;
  logic            order;

  irq_hub_sync #(.W(NSRC), .STAGES(2)) i_sync (
    .clk_i, .rst_ni, .d_i(irq_i), .q_o(sync)
  );

  irq_hub_sense #(.W(NSRC)) i_sense (
    .clk_i, .rst_ni, .sync_i(sync), .trig_i(trig), .pol_i(pol), .set_o(set)
  );

  irq_hub_regs i_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .set_i(set),
    .rdata_o, .masked_o(masked), .trig_o(trig), .pol_o(pol),
    .route_o(route), .order_o(order)
  );

  irq_hub_prio i_prio (
    .clk_i, .rst_ni, .masked_i(masked), .order_i(order),
    .idx_o(pend_idx_o), .vld_o(pend_vld_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      crit_o <= 1'b0;
    end else begin
      irq_o  <= |(masked & route);
      crit_o <= |(masked & ~route);
    end
  end

  // R6: outputs follow routed masked status one cycle later
  p_route_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(masked & route))));
  p_route_crit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (crit_o == $past(|(masked & ~route))));

  // R9: reserved sources are never reported
  p_rsvd_idx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_o |-> !(pend_idx_o >= IW'(17) && pend_idx_o <= IW'(19)));
endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, crit_o, vld;
  logic [4:0]  idx;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_hub i_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o),
    .crit_o(crit_o), .pend_idx_o(idx), .pend_vld_o(vld)
  );

  function automatic logic [31:0] b(int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic check(string req_s, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic cleanup();
    irq = '0;
    wr(3'd1, '0);
    wr(3'd3, '0);
    wr(3'd4, '1);
    wr(3'd5, '1);
    wr(3'd6, '0);
    settle();
    wr(3'd0, '1);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R10 status", d, '0);
    rd(3'd1, d); check("R10 enable", d, '0);
    rd(3'd3, d); check("R10 trig", d, '0);
    rd(3'd4, d); check("R10 pol", d, '1);
    rd(3'd5, d); check("R10 route", d, '1);
    rd(3'd6, d); check("R10 order", d, '0);
    check("R10 outputs", {29'd0, irq_o, crit_o, vld}, '0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(3'd1, b(3));
    @(negedge clk); irq = b(3);   // R1: source 3 on bit 28
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(3'd0, d); check("R11 status after 3 edges", d, b(3));
    check("R1 idx", {27'd0, idx}, 32'd3);
    @(negedge clk);
    check("R6 irq_o", {31'd0, irq_o}, 32'd1);
    wr(3'd0, b(3)); settle();
    rd(3'd0, d); check("R3 level re-asserts", d, b(3));
    irq = '0; settle();
    rd(3'd0, d); check("R3 sticky after drop", d, b(3));
    wr(3'd0, b(3)); settle();
    rd(3'd0, d); check("R3 cleared", d, '0);
    check("R6 irq_o low", {31'd0, irq_o}, 32'd0);
    cleanup();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    irq = b(1) | b(30); settle();
    irq = '0; settle();
    wr(3'd0, '0); settle();
    rd(3'd0, d); check("R2 write zero", d, b(1) | b(30));
    wr(3'd0, b(30)); settle();
    rd(3'd0, d); check("R2 one bit cleared", d, b(1));
    wr(3'd2, '1); settle();
    rd(3'd2, d); check("R2 masked read-only", d, '0);
    cleanup();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(3'd3, b(5));
    irq = b(5); settle();
    rd(3'd0, d); check("R4 rising edge sets", d, b(5));
    wr(3'd0, b(5)); settle();
    rd(3'd0, d); check("R4 held high stays clear", d, '0);
    irq = '0; settle();
    irq = b(5); settle();
    rd(3'd0, d); check("R4 new edge sets", d, b(5));
    cleanup();
  endtask

  task automatic t_pol();
    logic [31:0] d;
    wr(3'd4, ~b(7)); settle();
    rd(3'd0, d); check("R5 active-low level", d, b(7));
    cleanup();
    irq = b(8); settle();
    wr(3'd3, b(8));
    wr(3'd4, ~b(8)); settle();
    wr(3'd0, '1); settle();
    rd(3'd0, d); check("R5 no falling edge yet", d, '0);
    irq = '0; settle();
    rd(3'd0, d); check("R5 falling edge sets", d, b(8));
    cleanup();
  endtask

  task automatic t_route_mask();
    logic [31:0] d;
    wr(3'd5, ~b(10));
    wr(3'd1, b(10));
    irq = b(10) | b(11); settle();
    check("R6 crit_o", {30'd0, irq_o, crit_o}, 32'd1);
    rd(3'd2, d); check("R7 masked", d, b(10));
    check("R7 idx", {27'd0, idx}, 32'd10);
    wr(3'd1, '0); settle();
    check("R7 disabled quiet", {29'd0, irq_o, crit_o, vld}, '0);
    cleanup();
  endtask

  task automatic t_prio();
    wr(3'd1, '1);
    irq = b(2) | b(25); settle();
    check("R8 order0 idx", {26'd0, vld, idx}, {26'd0, 1'b1, 5'd2});
    wr(3'd6, 32'd1); settle();
    check("R8 order1 idx", {26'd0, vld, idx}, {26'd0, 1'b1, 5'd25});
    irq = '0; settle();
    wr(3'd0, '1); settle();
    check("R8 none valid", {31'd0, vld}, '0);
    cleanup();
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    wr(3'd1, '1);
    irq = b(17) | b(18) | b(19); settle();
    rd(3'd0, d); check("R9 status zero", d, '0);
    rd(3'd1, d); check("R9 enable bits zero", d & 32'h0000_7000, '0);
    check("R9 outputs quiet", {29'd0, irq_o, crit_o, vld}, '0);
    wr(3'd5, '0); settle();
    check("R9 crit quiet", {31'd0, crit_o}, '0);
    cleanup();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected < 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_w1c();
    t_edge();
    t_pol();
    t_route_mask();
    t_prio();
    t_rsvd();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule